// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores the on/off setting of each switch in a crosspoint array of twelve rows by eight columns. Each switch has one control bit, so there are 96 bits in all, and all of them are driven out in parallel on a flat state vector. The analog switches are built elsewhere and are driven from that vector. A host selects a cell with a four-bit row code and a three-bit column code. It places the desired value on `data_in` and holds `strobe` high. On every rising clock edge while `strobe` is high, the addressed cell is loaded from `data_in`. When `strobe` drops, the cell keeps the last value loaded.

The row code space is sparse. Codes 0 to 5 reach rows 0 to 5, and codes 8 to 13 reach rows 6 to 11. Codes 6, 7, 14 and 15 address nothing. Any number of cells may be on together, so one column may join several rows and one row may join several columns. An active-high reset clears every cell at once and does not wait for the clock. Reset also overrides any write that is in progress.

The block has no data stream, so it has no valid/ready handshake; every pin is a plain control level.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `rst` is high, `cell_state` is all zeros. Raising `rst` clears the cells at once, without waiting for a clock edge.
- R2: Row codes 0 to 5 select rows 0 to 5, and row codes 8 to 13 select rows 6 to 11. The written cell is bit `col*12 + row` of `cell_state`.
- R3: A write with row code 6, 7, 14 or 15 leaves all 96 bits of `cell_state` unchanged.
- R4: Column code c (0 to 7) selects column c directly, so columns 0 and 7 map to bits `row` and `84 + row`.
- R5: On each rising clock edge where `strobe` is high and the row code is valid, the addressed cell takes `data_in`. The cell therefore follows changes of `data_in` one cycle later for as long as `strobe` stays high.
- R6: Once `strobe` is low, the cell keeps the value loaded at the last edge where `strobe` was high. Changes to `data_in` or to the address while `strobe` is low have no effect on `cell_state`.
- R7: A write changes at most the one addressed bit. All other bits keep their values.
- R8: When `rst` and `strobe` are high together, reset wins, and `cell_state` stays zero.
- R9: Any set of cells may be 1 at the same time, including several rows in one column and several columns in one row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; `strobe` is sampled on its rising edge |
| rst | input | 1 | Asynchronous active-high clear of all cells |
| row_addr | input | 4 | Row code (sparse: 0-5 and 8-13 valid) |
| col_addr | input | 3 | Column code 0-7 |
| data_in | input | 1 | Value written to the addressed cell (1 = switch on) |
| strobe | input | 1 | Write enable level; cell is loaded each edge while high |
| cell_state | output | 96 | Current switch settings, bit index col*12+row |

## Verification
A wrong decode or a stuck cell shows up in the first cycle after the write: the 96-bit output will have the wrong bit set, or one extra bit changed. A write that leaks through a reserved row code, or through a low strobe, shows as an unexpected bit change on the same edge. A reset that is not asynchronous leaves nonzero bits visible before the next clock edge, so the bench samples within one nanosecond of raising reset.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;
  // Sparse row code: upper bits pick a bank, lower bits an offset inside it.
  function automatic int unsigned row_code_of(input int unsigned row,
                                              input int unsigned bank_rows,
                                              input int unsigned ofs_w);
    return ((row / bank_rows) << ofs_w) + (row % bank_rows);
  endfunction
endpackage

// File: rtl/xpt_row_decode.sv
`timescale 1ns/1ps
module xpt_row_decode #(
  parameter int unsigned BANK_ROWS = 6,
  parameter int unsigned BANKS     = 2,
  parameter int unsigned OFS_W     = $clog2(BANK_ROWS),
  parameter int unsigned ROW_AW    = OFS_W + $clog2(BANKS),
  parameter int unsigned ROWS      = BANK_ROWS * BANKS
) (
  input  logic [ROW_AW-1:0] row_addr,
  output logic [ROWS-1:0]   row_hot,
  output logic              row_valid
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [ROW_AW-1:0] CODE =
      ROW_AW'(xpt_pkg::row_code_of(r, BANK_ROWS, OFS_W));
    assign row_hot[r] = (row_addr == CODE);
  end
  assign row_valid = |row_hot;
endmodule

// File: rtl/xpt_col_decode.sv
`timescale 1ns/1ps
module xpt_col_decode #(
  parameter int unsigned COLS   = 8,
  parameter int unsigned COL_AW = $clog2(COLS)
) (
  input  logic [COL_AW-1:0] col_addr,
  output logic [COLS-1:0]   col_hot
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_hot[c] = (col_addr == COL_AW'(c));
  end
endmodule

// File: rtl/xpt_cell_array.sv
`timescale 1ns/1ps
module xpt_cell_array #(
  parameter int unsigned ROWS  = 12,
  parameter int unsigned COLS  = 8,
  parameter int unsigned CELLS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_val,
  input  logic [ROWS-1:0]  row_hot,
  input  logic [COLS-1:0]  col_hot,
  output logic [CELLS-1:0] cells
);
  for (genvar c = 0; c < COLS; c++) begin : g_c
    for (genvar r = 0; r < ROWS; r++) begin : g_r
      always_ff @(posedge clk or posedge rst) begin
        if (rst)
          cells[c*ROWS + r] <= 1'b0;
        else if (wr_en && col_hot[c] && row_hot[r])
          cells[c*ROWS + r] <= wr_val;
      end
    end
  end
endmodule

// File: rtl/xpt_ctrl_mem.sv
`timescale 1ns/1ps
module xpt_ctrl_mem #(
  parameter  int unsigned BANK_ROWS = 6,
  parameter  int unsigned BANKS     = 2,
  parameter  int unsigned COLS      = 8,
  localparam int unsigned OFS_W     = $clog2(BANK_ROWS),
  localparam int unsigned ROW_AW    = OFS_W + $clog2(BANKS),
  localparam int unsigned COL_AW    = $clog2(COLS),
  localparam int unsigned ROWS      = BANK_ROWS * BANKS,
  localparam int unsigned CELLS     = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROW_AW-1:0] row_addr,
  input  logic [COL_AW-1:0] col_addr,
  input  logic              data_in,
  input  logic              strobe,
  output logic [CELLS-1:0]  cell_state
);
  logic [ROWS-1:0] row_hot;
  logic [COLS-1:0] col_hot;
  logic            row_valid;
  logic            wr_en;

  xpt_row_decode #(
    .BANK_ROWS(BANK_ROWS), .BANKS(BANKS), .OFS_W(OFS_W),
    .ROW_AW(ROW_AW), .ROWS(ROWS)
  ) u_row (
    .row_addr(row_addr), .row_hot(row_hot), .row_valid(row_valid)
  );

  xpt_col_decode #(.COLS(COLS), .COL_AW(COL_AW)) u_col (
    .col_addr(col_addr), .col_hot(col_hot)
  );

  // Reserved row codes never raise the enable, so they cannot touch a cell.
  assign wr_en = strobe & row_valid;

  xpt_cell_array #(.ROWS(ROWS), .COLS(COLS), .CELLS(CELLS)) u_cells (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_val(data_in),
    .row_hot(row_hot), .col_hot(col_hot), .cells(cell_state)
  );
endmodule

// File: rtl/xpt_ctrl_mem_chk.sv
`timescale 1ns/1ps
module xpt_ctrl_mem_chk #(
  parameter int unsigned BANK_ROWS = 6,
  parameter int unsigned BANKS     = 2,
  parameter int unsigned COLS      = 8,
  parameter int unsigned OFS_W     = $clog2(BANK_ROWS),
  parameter int unsigned ROW_AW    = OFS_W + $clog2(BANKS),
  parameter int unsigned COL_AW    = $clog2(COLS),
  parameter int unsigned ROWS      = BANK_ROWS * BANKS,
  parameter int unsigned CELLS     = ROWS * COLS
) (
  input logic              clk,
  input logic              rst,
  input logic [ROW_AW-1:0] row_addr,
  input logic [COL_AW-1:0] col_addr,
  input logic              data_in,
  input logic              strobe,
  input logic [CELLS-1:0]  cell_state
);
  localparam int unsigned IDX_W = $clog2(CELLS);
  logic             rsvd;
  logic [IDX_W-1:0] tgt;

  always_comb begin
    rsvd = (int'(row_addr[OFS_W-1:0]) >= int'(BANK_ROWS));
    tgt  = IDX_W'(int'(col_addr) * int'(ROWS)
                  + int'(row_addr >> OFS_W) * int'(BANK_ROWS)
                  + int'(row_addr[OFS_W-1:0]));
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |-> cell_state == '0);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobe)) |-> $stable(cell_state));

  // R3
  reserved_row_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobe) && $past(rsvd)) |-> $stable(cell_state));

  // R7
  single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(cell_state ^ $past(cell_state)) <= 1);

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobe) && !$past(rsvd))
      |-> cell_state[$past(tgt)] == $past(data_in));
endmodule

bind xpt_ctrl_mem xpt_ctrl_mem_chk #(
  .BANK_ROWS(BANK_ROWS), .BANKS(BANKS), .COLS(COLS)
) u_chk (
  .clk(clk), .rst(rst), .row_addr(row_addr), .col_addr(col_addr),
  .data_in(data_in), .strobe(strobe), .cell_state(cell_state)
);

// File: tb/xpt_ctrl_mem_test.sv
`timescale 1ns/1ps
module xpt_ctrl_mem_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  row_addr = '0;
  logic [2:0]  col_addr = '0;
  logic        data_in = 1'b0;
  logic        strobe = 1'b0;
  logic [95:0] cell_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [95:0] model = '0;

  always #2.5 clk = ~clk;

  xpt_ctrl_mem uut (
    .clk(clk), .rst(rst), .row_addr(row_addr), .col_addr(col_addr),
    .data_in(data_in), .strobe(strobe), .cell_state(cell_state)
  );

  typedef struct packed {
    logic [3:0] row;
    logic [2:0] col;
    logic       d;
    logic [6:0] idx;   // 127 = no cell
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  3'd0, 1'b1, 7'd0},    // R2 R4
    '{4'd5,  3'd0, 1'b1, 7'd5},    // R2
    '{4'd8,  3'd0, 1'b1, 7'd6},    // R2
    '{4'd13, 3'd0, 1'b1, 7'd11},   // R2 R9
    '{4'd0,  3'd7, 1'b1, 7'd84},   // R4 R9
    '{4'd13, 3'd7, 1'b1, 7'd95},   // R4
    '{4'd6,  3'd3, 1'b1, 7'd127},  // R3
    '{4'd7,  3'd3, 1'b1, 7'd127},  // R3
    '{4'd14, 3'd2, 1'b1, 7'd127},  // R3
    '{4'd15, 3'd5, 1'b1, 7'd127},  // R3
    '{4'd3,  3'd4, 1'b1, 7'd51},   // R2
    '{4'd5,  3'd0, 1'b0, 7'd5},    // R7
    '{4'd9,  3'd2, 1'b1, 7'd31},   // R2
    '{4'd12, 3'd6, 1'b1, 7'd82},   // R2
    '{4'd15, 3'd7, 1'b0, 7'd127}   // R3
  };

  task automatic chk(input string req, input logic [95:0] act,
                     input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_once(input logic [3:0] r, input logic [2:0] c,
                            input logic d);
    @(negedge clk);
    row_addr = r; col_addr = c; data_in = d; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset state", cell_state, '0);
    rst = 1'b0;

    // Table walk covering R2, R3, R4, R7, R9
    for (int i = 0; i < NV; i++) begin
      write_once(VEC[i].row, VEC[i].col, VEC[i].d);
      if (VEC[i].idx != 7'd127) model[VEC[i].idx] = VEC[i].d;
      chk("R2/R3/R4/R7 table", cell_state, model);
    end

    // R5: cell follows data while strobe held high (row 2, col 1 -> bit 14)
    @(negedge clk);
    row_addr = 4'd2; col_addr = 3'd1; data_in = 1'b1; strobe = 1'b1;
    @(negedge clk);
    model[14] = 1'b1;
    chk("R5 follow high", cell_state, model);
    data_in = 1'b0;
    @(negedge clk);
    model[14] = 1'b0;
    chk("R5 follow low", cell_state, model);
    data_in = 1'b1;
    @(negedge clk);
    model[14] = 1'b1;
    chk("R5 follow high again", cell_state, model);

    // R6: drop strobe and data together; value loaded last is kept
    strobe = 1'b0; data_in = 1'b0;
    @(negedge clk);
    chk("R6 hold after strobe fall", cell_state, model);
    row_addr = 4'd4; col_addr = 3'd3; data_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 inputs ignored with strobe low", cell_state, model);

    // R1 asynchronous clear and R8 priority over an active write
    strobe = 1'b1; row_addr = 4'd1; col_addr = 3'd0; data_in = 1'b1;
    #0.5 rst = 1'b1;
    #0.5;
    chk("R1 async clear before edge", cell_state, '0);
    @(negedge clk);
    chk("R8 reset beats strobe", cell_state, '0);
    strobe = 1'b0; rst = 1'b0;
    model = '0;
    @(negedge clk);
    chk("R8 still clear after release", cell_state, model);

    // R9: one row across several columns, then R7 clear of one
    write_once(4'd10, 3'd0, 1'b1); model[8]  = 1'b1;
    write_once(4'd10, 3'd3, 1'b1); model[44] = 1'b1;
    write_once(4'd10, 3'd5, 1'b1); model[68] = 1'b1;
    chk("R9 one row many columns", cell_state, model);
    write_once(4'd10, 3'd3, 1'b0); model[44] = 1'b0;
    chk("R7 only addressed bit cleared", cell_state, model);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks, fails);
    $finish;
  end
endmodule